// File: doc/BRIEF.md
# Receive Packet Queue with Word Read Port

This block sits between a receive MAC and a processor. Frames arrive as a byte stream: `in_valid` qualifies each byte, `in_start` marks the first byte and `in_end` the last. A single-byte frame carries both marks on the same beat. Each accepted frame is stored in its own slot of a ring of `SLOTS` slots, each `SLOT_BYTES` bytes deep. The default slot size is 256 bytes so the default build stays small. The slot size can be raised to 2048.

The block wraps every stored frame. It writes a 16-bit length ahead of the frame bytes and a CRC-32 trailer after them. The length is the frame size plus 6. The CRC is built one byte per cycle as the bytes arrive, and any bytes left over in the last 32-bit word are filled with zeros.

The processor pulses `rd_strobe` to read one 32-bit word, which appears on `rd_data` one cycle later. Successive reads walk through the current packet. When its last word has been read, the queue moves to the next packet without any further command.

`pend_count` shows how many packets are waiting. `rx_irq` pulses for one cycle each time a frame is stored. `fifo_flush` discards everything that is queued. The source must leave at least 8 idle cycles between the end of one frame and the start of the next.

The writer state machine has these states:
- `W_IDLE`: waits for a start beat. It goes to `W_DATA` when the frame is accepted, or to `W_DROP` when the frame is refused.
- `W_DATA`: stores bytes. It goes to `W_CRC` on the end beat, or to `W_DROP` when the slot would overflow.
- `W_DROP`: ignores bytes until the end beat, then returns to `W_IDLE`.
- `W_CRC`: emits the four CRC bytes. It goes to `W_PAD` when the packet is not word aligned, otherwise straight to `W_HDR`.
- `W_PAD`: writes zero bytes until the packet is word aligned, then goes to `W_HDR`.
- `W_HDR`: back-patches the length into word 0, commits the packet and returns to `W_IDLE`.

The reader state machine has two states. It moves from `R_IDLE` to `R_ACTIVE` when a read starts a packet that has more than one word. It returns from `R_ACTIVE` to `R_IDLE` when the last word of that packet is read, or on a flush.

Top module: `rx_word_queue`

## Requirements
- R1: At most `SLOTS` (31) packets are pending. A frame whose start beat arrives while 31 are pending is discarded, and `pend_count` stays 31.
- R2: A frame whose start beat arrives while `rx_en` is low is discarded entirely. It causes no count change and no `rx_irq`.
- R3: Bits 15:0 of a packet's first word hold the frame byte count plus 6, with the low byte in bits 7:0.
- R4: Frame byte k is stored at packet byte k+2. Stored byte j is returned in word j/4, at bit position 8*(j mod 4).
- R5: The 4 bytes after the frame hold the CRC-32 of the frame bytes, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, starts from 0xFFFFFFFF and is inverted at the end. For the 9-byte frame "123456789" the CRC is 0xCBF43926.
- R6: If the stored length is not a multiple of 4, the unused upper bytes of the last word read as zero.
- R7: Each `rd_strobe` returns the next word of the current packet on `rd_data` in the following cycle. After the last word, the next read starts the following packet, and `pend_count` drops by one.
- R8: A read while nothing is pending returns 0 and leaves `pend_count` at 0.
- R9: A `fifo_flush` pulse sets `pend_count` to 0 and abandons the partly read packet. The next stored frame is then read from its length word.
- R10: `rx_irq` pulses high for exactly one cycle for each stored frame, and never for a discarded one.
- R11: A frame longer than `SLOT_BYTES`-6 bytes is discarded. A frame of exactly `SLOT_BYTES`-6 bytes is stored whole.
- R12: When a frame is stored in the same cycle as a packet finishes draining, `pend_count` is unchanged. The count never moves by more than one per cycle except on a flush.
- R13: After reset, `pend_count`, `rd_data` and `rx_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable, sampled on the start beat |
| fifo_flush | input | 1 | Discard all pending packets (pulse) |
| in_valid | input | 1 | Byte valid |
| in_start | input | 1 | First byte of a frame |
| in_end | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| rd_strobe | input | 1 | Read one word (pulse) |
| rd_data | output | 32 | Word returned one cycle after the strobe |
| pend_count | output | $clog2(SLOTS+1) | Packets pending |
| rx_irq | output | 1 | One-cycle pulse per stored frame |

## Verification
The assertions watch, on every cycle, the properties that a single state or a single clock step can express:
- the count stays within its bound and moves by at most one per cycle;
- a flush empties the queue;
- an underflowing read yields zero;
- the interrupt is a single-cycle pulse;
- a refused or oversize frame sends the writer into `W_DROP`;
- the header back-patch happens only on a word boundary.

Stored content can only be shown by the bench's scenarios, which read frames back and compare them word by word with a model. These scenarios cover the length header, byte packing, the CRC trailer (including a known check value), zero padding, automatic advance across packets, the 31-packet limit, a frame exactly at the size limit, and a flush in the middle of a packet.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    typedef enum logic [2:0] {
        W_IDLE, W_DATA, W_DROP, W_CRC, W_PAD, W_HDR
    } wr_state_e;

    typedef enum logic {
        R_IDLE, R_ACTIVE
    } rd_state_e;

    // One byte of a reflected CRC-32, bit-serial inside the step.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int SLOTS      = 31,
    parameter int SLOT_BYTES = 256,
    localparam int SLOT_WORDS = SLOT_BYTES / 4,
    localparam int SW    = $clog2(SLOTS),
    localparam int WW    = $clog2(SLOT_WORDS),
    localparam int BW    = $clog2(SLOT_BYTES + 1),
    localparam int DEPTH = SLOTS * SLOT_WORDS,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] w_slot,
    input  logic [WW-1:0] w_word,
    input  logic [31:0]   w_data,
    input  logic          len_we,
    input  logic [BW-1:0] len_val,
    input  logic          r_en,
    input  logic [SW-1:0] r_slot,
    input  logic [WW-1:0] r_word,
    output logic [31:0]   r_data,
    output logic [BW-1:0] head_len
);

    logic [31:0]   mem  [DEPTH];
    logic [BW-1:0] lens [SLOTS];
    logic [AW-1:0] waddr, raddr;

    assign waddr    = AW'(w_slot) * AW'(SLOT_WORDS) + AW'(w_word);
    assign raddr    = AW'(r_slot) * AW'(SLOT_WORDS) + AW'(r_word);
    assign head_len = lens[r_slot];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= w_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_data <= '0;
            for (int i = 0; i < SLOTS; i++) lens[i] <= '0;
        end else begin
            if (r_en)   r_data <= mem[raddr];
            if (len_we) lens[w_slot] <= len_val;
        end
    end

endmodule

// File: rtl/rxq_writer.sv
module rxq_writer
    import rxq_pkg::*;
#(
    parameter int SLOTS      = 31,
    parameter int SLOT_BYTES = 256,
    localparam int SLOT_WORDS = SLOT_BYTES / 4,
    localparam int SW = $clog2(SLOTS),
    localparam int WW = $clog2(SLOT_WORDS),
    localparam int BW = $clog2(SLOT_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          flush,
    input  logic          in_valid,
    input  logic          in_start,
    input  logic          in_end,
    input  logic [7:0]    in_data,
    input  logic          q_full,
    input  logic [SW-1:0] tail_slot,
    output logic          mem_we,
    output logic [SW-1:0] mem_slot,
    output logic [WW-1:0] mem_word,
    output logic [31:0]   mem_wdata,
    output logic          commit,
    output logic [BW-1:0] commit_len
);

    localparam logic [BW-1:0] FULL_AT = BW'(SLOT_BYTES - 4);

    wr_state_e     st, st_nx;
    logic [SW-1:0] slot_q;
    logic [BW-1:0] bcnt, len_q, bpos;
    logic [31:0]   acc, crc, crc_fin, base, wword;
    logic [15:0]   w0_hi;
    logic [1:0]    cidx, lane;
    logic          push, beat_end, frame_open;
    logic [7:0]    pbyte;

    // next-state logic
    always_comb begin
        st_nx      = st;
        beat_end   = in_valid && in_end;
        frame_open = (st == W_DATA || st == W_DROP || (st == W_IDLE && in_valid && in_start))
                     && !beat_end;
        unique case (st)
            W_IDLE: if (in_valid && in_start) begin
                if (!rx_en || q_full) st_nx = in_end ? W_IDLE : W_DROP;
                else                  st_nx = in_end ? W_CRC  : W_DATA;
            end
            W_DATA: if (in_valid) begin
                if (bcnt == FULL_AT) st_nx = in_end ? W_IDLE : W_DROP;
                else if (in_end)     st_nx = W_CRC;
            end
            W_DROP: if (beat_end) st_nx = W_IDLE;
            W_CRC:  if (cidx == 2'd3) st_nx = (bcnt[1:0] == 2'd3) ? W_HDR : W_PAD;
            W_PAD:  if (bcnt[1:0] == 2'd3) st_nx = W_HDR;
            W_HDR:  st_nx = W_IDLE;
            default: st_nx = W_IDLE;
        endcase
        if (flush) st_nx = frame_open ? W_DROP : W_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= W_IDLE;
        else        st <= st_nx;
    end

    // byte push and memory-side outputs
    always_comb begin
        bpos    = (st == W_IDLE) ? BW'(2) : bcnt;
        lane    = bpos[1:0];
        base    = (st == W_IDLE) ? 32'h0 : acc;
        crc_fin = ~crc;
        pbyte   = in_data;
        push    = 1'b0;
        unique case (st)
            W_IDLE: push = in_valid && in_start && rx_en && !q_full;
            W_DATA: push = in_valid && (bcnt != FULL_AT);
            W_CRC:  begin push = 1'b1; pbyte = crc_fin[8*cidx +: 8]; end
            W_PAD:  begin push = 1'b1; pbyte = 8'h00; end
            default: push = 1'b0;
        endcase
        push = push && !flush;
        wword = base;
        wword[8*lane +: 8] = pbyte;
        commit     = (st == W_HDR) && !flush;
        commit_len = len_q;
        mem_we     = (push && lane == 2'd3) || commit;
        mem_slot   = (st == W_IDLE) ? tail_slot : slot_q;
        mem_word   = (st == W_HDR) ? '0 : WW'(bpos >> 2);
        mem_wdata  = (st == W_HDR) ? {w0_hi, 16'(len_q)} : wword;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            bcnt   <= '0;
            len_q  <= '0;
            acc    <= '0;
            crc    <= '1;
            w0_hi  <= '0;
            cidx   <= '0;
        end else begin
            if (st == W_IDLE) slot_q <= tail_slot;
            if (push) begin
                bcnt <= bpos + 1'b1;
                acc  <= (lane == 2'd3) ? 32'h0 : wword;
                if (bpos == BW'(2)) w0_hi[7:0]  <= pbyte;
                if (bpos == BW'(3)) w0_hi[15:8] <= pbyte;
            end
            if (push && (st == W_IDLE || st == W_DATA)) begin
                crc <= crc_step((st == W_IDLE) ? 32'hFFFF_FFFF : crc, in_data);
                if (in_end) len_q <= bpos + BW'(5);
            end
            cidx <= (st == W_CRC) ? cidx + 2'd1 : 2'd0;
        end
    end

    // R10: one pulse per stored frame
    a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    // R2: refused start beat leads to discard
    a_r2_disabled_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_IDLE && in_valid && in_start && !in_end && !rx_en && !flush) |=> (st == W_DROP));
    // R11: a byte past slot capacity abandons the frame
    a_r11_oversize_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_DATA && in_valid && !in_end && bcnt == FULL_AT && !flush) |=> (st == W_DROP));
    // R6: header back-patch only once the packet is word aligned
    a_r6_aligned_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_HDR) |-> (bcnt[1:0] == 2'd0));

endmodule

// File: rtl/rxq_reader.sv
module rxq_reader
    import rxq_pkg::*;
#(
    parameter int SLOTS      = 31,
    parameter int SLOT_BYTES = 256,
    localparam int SLOT_WORDS = SLOT_BYTES / 4,
    localparam int SW = $clog2(SLOTS),
    localparam int WW = $clog2(SLOT_WORDS),
    localparam int BW = $clog2(SLOT_BYTES + 1),
    localparam int CW = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          commit,
    input  logic          rd_strobe,
    input  logic [BW-1:0] head_len,
    input  logic [31:0]   mem_q,
    output logic [SW-1:0] head_slot,
    output logic [SW-1:0] tail_slot,
    output logic          q_full,
    output logic [CW-1:0] pend_count,
    output logic          rd_en,
    output logic [WW-1:0] rd_word,
    output logic [31:0]   rd_data
);

    rd_state_e     rs, rs_nx;
    logic [BW-1:0] rem, cur_rem;
    logic [WW-1:0] ptr, cur_ptr;
    logic [SW-1:0] head;
    logic [CW-1:0] count;
    logic [SW:0]   tsum;
    logic          take, last, drain, uf_q;

    always_comb begin
        take    = rd_strobe && (rs == R_ACTIVE || count != '0);
        cur_rem = (rs == R_IDLE) ? head_len : rem;
        cur_ptr = (rs == R_IDLE) ? '0 : ptr;
        last    = cur_rem <= BW'(4);
        drain   = take && last && !flush;
        rs_nx   = rs;
        unique case (rs)
            R_IDLE:   if (take && !last) rs_nx = R_ACTIVE;
            R_ACTIVE: if (take && last)  rs_nx = R_IDLE;
            default:  rs_nx = R_IDLE;
        endcase
        if (flush) rs_nx = R_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs <= R_IDLE;
        else        rs <= rs_nx;
    end

    always_comb begin
        tsum       = (SW+1)'(head) + (SW+1)'(count);
        tail_slot  = (tsum >= (SW+1)'(SLOTS)) ? SW'(tsum - (SW+1)'(SLOTS)) : SW'(tsum);
        q_full     = count == CW'(SLOTS);
        head_slot  = head;
        pend_count = count;
        rd_en      = take;
        rd_word    = cur_ptr;
        rd_data    = uf_q ? 32'h0 : mem_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            ptr   <= '0;
            head  <= '0;
            count <= '0;
            uf_q  <= 1'b0;
        end else begin
            if (rd_strobe) uf_q <= !take;
            if (take) begin
                ptr <= cur_ptr + 1'b1;
                rem <= cur_rem - BW'(4);
            end
            if (drain) head <= (head == SW'(SLOTS - 1)) ? '0 : head + 1'b1;
            if (flush) count <= '0;
            else begin
                unique case ({commit, drain})
                    2'b10:   count <= count + 1'b1;
                    2'b01:   count <= count - 1'b1;
                    default: count <= count;
                endcase
            end
        end
    end

    // R1: never more than SLOTS pending
    a_r1_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(SLOTS));
    // R12: count moves by at most one per cycle outside a flush
    a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (count == $past(count) || count == $past(count) + 1'b1
                    || count == $past(count) - 1'b1));
    // R9: flush empties the queue and abandons the current packet
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && rs == R_IDLE));
    // R8: underflow read yields zero
    a_r8_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rs == R_IDLE && count == '0) |=> (rd_data == 32'h0));
    // R7: head index stays inside the ring
    a_r7_head_range: assert property (@(posedge clk) disable iff (!rst_n)
        head < SW'(SLOTS));

endmodule

// File: rtl/rx_word_queue.sv
module rx_word_queue #(
    parameter int SLOTS      = 31,
    parameter int SLOT_BYTES = 256,
    localparam int SLOT_WORDS = SLOT_BYTES / 4,
    localparam int SW = $clog2(SLOTS),
    localparam int WW = $clog2(SLOT_WORDS),
    localparam int BW = $clog2(SLOT_BYTES + 1),
    localparam int CW = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          fifo_flush,
    input  logic          in_valid,
    input  logic          in_start,
    input  logic          in_end,
    input  logic [7:0]    in_data,
    input  logic          rd_strobe,
    output logic [31:0]   rd_data,
    output logic [CW-1:0] pend_count,
    output logic          rx_irq
);

    logic          q_full, mem_we, commit, rd_en;
    logic [SW-1:0] tail_slot, head_slot, mem_slot;
    logic [WW-1:0] mem_word, rd_word;
    logic [31:0]   mem_wdata, mem_q;
    logic [BW-1:0] commit_len, head_len;

    rxq_writer #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_wr (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .flush(fifo_flush),
        .in_valid(in_valid), .in_start(in_start), .in_end(in_end), .in_data(in_data),
        .q_full(q_full), .tail_slot(tail_slot),
        .mem_we(mem_we), .mem_slot(mem_slot), .mem_word(mem_word), .mem_wdata(mem_wdata),
        .commit(commit), .commit_len(commit_len)
    );

    rxq_store #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .w_slot(mem_slot), .w_word(mem_word), .w_data(mem_wdata),
        .len_we(commit), .len_val(commit_len),
        .r_en(rd_en), .r_slot(head_slot), .r_word(rd_word), .r_data(mem_q),
        .head_len(head_len)
    );

    rxq_reader #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_rd (
        .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .commit(commit),
        .rd_strobe(rd_strobe), .head_len(head_len), .mem_q(mem_q),
        .head_slot(head_slot), .tail_slot(tail_slot), .q_full(q_full),
        .pend_count(pend_count), .rd_en(rd_en), .rd_word(rd_word), .rd_data(rd_data)
    );

    assign rx_irq = commit;

endmodule

// File: tb/rx_word_queue_test.sv
module rx_word_queue_test;

    localparam int SLOTS      = 31;
    localparam int SLOT_BYTES = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, fifo_flush = 1'b0;
    logic        in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0;
    logic [7:0]  in_data = 8'h0;
    logic        rd_strobe = 1'b0;
    logic [31:0] rd_data;
    logic [4:0]  pend_count;
    logic        rx_irq;

    rx_word_queue #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fifo_flush(fifo_flush),
        .in_valid(in_valid), .in_start(in_start), .in_end(in_end), .in_data(in_data),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .pend_count(pend_count), .rx_irq(rx_irq)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int exp_cnt = 0, exp_irq = 0, irq_seen = 0;
    logic [7:0]  frame[$];
    logic [31:0] expq[$];
    int          pkt_words[$];

    always @(posedge clk) if (rst_n && rx_irq) irq_seen++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_ref();
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (frame[i]) begin
            c = c ^ {24'h0, frame[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic void model_store();
        logic [7:0]  b[$];
        logic [31:0] c;
        int          total;
        total = frame.size() + 6;
        b.push_back(total[7:0]);
        b.push_back(total[15:8]);
        foreach (frame[i]) b.push_back(frame[i]);
        c = crc_ref();
        for (int k = 0; k < 4; k++) b.push_back(c[8*k +: 8]);
        while (b.size() % 4 != 0) b.push_back(8'h00);
        for (int w = 0; w < b.size() / 4; w++)
            expq.push_back({b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]});
        pkt_words.push_back(b.size() / 4);
    endfunction

    task automatic make_frame(input int len);
        frame.delete();
        for (int i = 0; i < len; i++) frame.push_back(8'($urandom));
    endtask

    task automatic send_frame(input bit gaps);
        bit accept;
        accept = rx_en && (exp_cnt < SLOTS) && (frame.size() <= SLOT_BYTES - 6);
        for (int i = 0; i < frame.size(); i++) begin
            if (gaps && ($urandom % 5 == 0)) begin
                @(negedge clk);
                in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (i == 0);
            in_end   = (i == frame.size() - 1);
            in_data  = frame[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
        repeat (12) @(negedge clk);
        if (accept) begin
            model_store();
            exp_cnt++;
            exp_irq++;
        end
    endtask

    task automatic read_word(output logic [31:0] v);
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        v = rd_data;
    endtask

    task automatic read_expect(input string tag, output logic [31:0] got);
        logic [31:0] exp;
        read_word(got);
        if (pkt_words.size() == 0) exp = 32'h0;
        else begin
            exp = expq.pop_front();
            pkt_words[0] = pkt_words[0] - 1;
            if (pkt_words[0] == 0) begin
                void'(pkt_words.pop_front());
                exp_cnt--;
            end
        end
        check(tag, got, exp);
    endtask

    task automatic drain_all(input string tag);
        logic [31:0] v;
        while (pkt_words.size() > 0) read_expect(tag, v);
    endtask

    task automatic do_flush();
        @(negedge clk) fifo_flush = 1'b1;
        @(negedge clk) fifo_flush = 1'b0;
        expq.delete();
        pkt_words.delete();
        exp_cnt = 0;
    endtask

    task automatic chk_count(input string tag);
        check(tag, 32'(pend_count), 32'(exp_cnt));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check("R13 count", 32'(pend_count), 0);
        check("R13 rd_data", rd_data, 0);
        check("R13 irq", 32'(rx_irq), 0);

        // R8 underflow
        read_expect("R8 underflow", v);
        check("R8 underflow literal", v, 32'h0);
        chk_count("R8 count");

        // R3 R5 R6 known CRC vector
        rx_en = 1'b1;
        frame.delete();
        for (int i = 0; i < 9; i++) frame.push_back(8'h31 + 8'(i));
        send_frame(1'b0);
        chk_count("R12 count after store");
        read_expect("R3 hdr", v);   check("R3 header literal", v, 32'h3231000F);
        read_expect("R4 data", v);  check("R4 data literal", v, 32'h36353433);
        read_expect("R5 crc", v);   check("R5 crc low byte", v, 32'h26393837);
        read_expect("R6 pad", v);   check("R6 crc high and pad", v, 32'h00CBF439);
        chk_count("R7 count after drain");
        check("R10 irq count", 32'(irq_seen), 32'(exp_irq));

        // R4 R6 R7 short frames, all lane alignments, back-to-back packets
        for (int len = 1; len <= 8; len++) begin
            make_frame(len);
            send_frame(1'b1);
        end
        chk_count("R7 eight pending");
        drain_all("R4 R6 R7 short frames");
        chk_count("R7 drained");

        // R2 disabled receive
        rx_en = 1'b0;
        make_frame(10);
        send_frame(1'b0);
        chk_count("R2 count unchanged");
        check("R2 irq unchanged", 32'(irq_seen), 32'(exp_irq));
        rx_en = 1'b1;

        // R11 size limit
        make_frame(SLOT_BYTES - 5);
        send_frame(1'b0);
        chk_count("R11 oversize dropped");
        make_frame(SLOT_BYTES - 6);
        send_frame(1'b0);
        chk_count("R11 max stored");
        drain_all("R11 max frame content");
        check("R10 irq after size tests", 32'(irq_seen), 32'(exp_irq));

        // R1 full queue
        for (int i = 0; i < SLOTS + 1; i++) begin
            make_frame(4 + (i % 5));
            send_frame(1'b0);
        end
        check("R1 count at capacity", 32'(pend_count), 32'(SLOTS));
        check("R1 irq no extra", 32'(irq_seen), 32'(exp_irq));
        drain_all("R1 ring contents");
        chk_count("R1 empty after drain");
        read_expect("R8 underflow after wrap", v);

        // R9 flush mid-packet
        make_frame(20); send_frame(1'b0);
        make_frame(13); send_frame(1'b0);
        read_expect("R9 partial read", v);
        do_flush();
        chk_count("R9 flushed");
        make_frame(7); send_frame(1'b0);
        read_expect("R9 header after flush", v);
        check("R9 header literal", v & 32'h0000FFFF, 32'd13);
        drain_all("R9 rest");

        // R12 store and drain overlapping
        for (int i = 0; i < 3; i++) begin make_frame(20); send_frame(1'b0); end
        make_frame(40);
        fork
            send_frame(1'b0);
            begin
                logic [31:0] w;
                for (int i = 0; i < 21; i++) read_expect("R12 concurrent read", w);
            end
        join
        chk_count("R12 concurrent count");
        drain_all("R12 tail packet");

        // constrained random mix
        for (int it = 0; it < 60; it++) begin
            if (($urandom % 3 != 0) && exp_cnt < SLOTS) begin
                make_frame(1 + int'($urandom % 64));
                send_frame(1'b1);
            end else begin
                for (int k = 0; k < 1 + int'($urandom % 8); k++) read_expect("R7 random read", v);
            end
            chk_count("R12 random count");
        end
        drain_all("R4 R5 random drain");
        check("R10 irq total", 32'(irq_seen), 32'(exp_irq));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule